// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the flag-conditioned control transfers of an 8-bit processor core that addresses 64 KiB. The core's fetch logic has already collected the opcode byte and, where one applies, the two bytes of the target address. It has also moved the program counter past those bytes. The fetch logic hands these to the block together with a copy of the flag register and a one-cycle start strobe.

The block has three jobs. It decodes which flag test the opcode names and which of three kinds of transfer is meant: an absolute jump, a subroutine call or a subroutine return. It then reports where execution resumes and how many clock states the instruction costs, and that cost depends on whether the transfer happened. A call or return that happens talks to the stack through a request/acknowledge pair. A push carries the return address, and a pop brings back a word that becomes the new program counter.

Any opcode that is not one of the twenty-four conditional transfers is reported as illegal and completes at once without changing the program counter.

Top module: `branch_resolve_unit`

## Requirements
- R1: The condition field is opcode bits 5:3. The codes mean: 000 zero flag clear, 001 zero flag set, 010 carry clear, 011 carry set, 100 parity/overflow clear, 101 parity/overflow set, 110 sign clear, 111 sign set.
- R2: The flags read by the tests are at these positions of the flag input: carry bit 0, parity/overflow bit 2, zero bit 6, sign bit 7. No other flag bit influences the outcome.
- R3: An opcode of the form 11ccc010 is a jump. If its condition holds, next_pc is the target; otherwise it is pc_i. In both cases tstates is 10 and no stack request is made.
- R4: An opcode of the form 11ccc100 is a call. If its condition holds, the block requests a push of pc_i, and then next_pc is the target, tstates is 17 and taken is 1. If the condition fails, next_pc is pc_i and tstates is 10.
- R5: An opcode of the form 11ccc000 is a return. If its condition holds, the block requests a pop, and then next_pc is the popped word and tstates is 11. If the condition fails, next_pc is pc_i and tstates is 5.
- R6: The target is formed with tgt_lo_i as bits 7:0 and tgt_hi_i as bits 15:8.
- R7: A start that needs no stack access produces done on the first rising edge after the start edge, and no push or pop request is raised. Push and pop are never requested together.
- R8: A stack request is raised on the edge that accepts start. It stays high, with push_data unchanged, until the edge that samples stack_ack. done rises on that same edge and the request falls.
- R9: Any opcode outside the three forms completes like R7 with illegal=1, taken=0, next_pc=pc_i and tstates=0.
- R10: A start strobe that arrives while a stack request is outstanding, including the cycle in which the acknowledge arrives, is ignored and produces no done.
- R11: After reset, done, push_req, pop_req, taken and illegal are 0, and next_pc and tstates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to resolve an instruction |
| opcode_i | input | 8 | Opcode byte |
| flags_i | input | 8 | Flag register |
| pc_i | input | 16 | Program counter past the operands |
| tgt_lo_i | input | 8 | Target address low byte |
| tgt_hi_i | input | 8 | Target address high byte |
| push_req_o | output | 1 | Push request to the stack |
| push_data_o | output | 16 | Word to push (return address) |
| pop_req_o | output | 1 | Pop request to the stack |
| pop_data_i | input | 16 | Word returned by a pop |
| stack_ack_i | input | 1 | Stack acknowledge for the pending request |
| done_o | output | 1 | One-cycle completion pulse |
| next_pc_o | output | 16 | Resume address, valid with done |
| tstates_o | output | 5 | Clock-state count, valid with done |
| taken_o | output | 1 | Condition held and transfer performed |
| illegal_o | output | 1 | Opcode is not a conditional transfer |

## Verification
Two events can meet in one cycle: the stack acknowledge that completes a taken call or return, and a fresh start strobe. To provoke this, the bench raises start with an illegal opcode in the same cycle as the acknowledge. It then checks two things. The completion must carry the results of the first instruction. In the following cycle no second done may appear, because the block was still busy when the strobe arrived. The block is also exercised under delayed acknowledges, and the request and its push word must hold steady across the wait.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [1:0] {
    GRP_JP   = 2'd0,
    GRP_CALL = 2'd1,
    GRP_RET  = 2'd2,
    GRP_BAD  = 2'd3
  } grp_e;

  // flag positions tested by the condition field
  localparam int unsigned FLG_C  = 0;
  localparam int unsigned FLG_PV = 2;
  localparam int unsigned FLG_Z  = 6;
  localparam int unsigned FLG_S  = 7;

  // clock-state costs
  localparam int unsigned TS_JP       = 10;
  localparam int unsigned TS_CALL_YES = 17;
  localparam int unsigned TS_CALL_NO  = 10;
  localparam int unsigned TS_RET_YES  = 11;
  localparam int unsigned TS_RET_NO   = 5;
  localparam int unsigned TS_BAD      = 0;

  // cc[2:1] picks the flag, cc[0] is the level that satisfies the test
  function automatic logic cond_met(input logic [2:0] cc, input logic [7:0] fl);
    logic sel;
    case (cc[2:1])
      2'd0:    sel = fl[FLG_Z];
      2'd1:    sel = fl[FLG_C];
      2'd2:    sel = fl[FLG_PV];
      default: sel = fl[FLG_S];
    endcase
    return sel == cc[0];
  endfunction

  function automatic grp_e grp_of(input logic [7:0] op);
    grp_e g;
    g = GRP_BAD;
    if (op[7:6] == 2'b11) begin
      case (op[2:0])
        3'b010:  g = GRP_JP;
        3'b100:  g = GRP_CALL;
        3'b000:  g = GRP_RET;
        default: g = GRP_BAD;
      endcase
    end
    return g;
  endfunction

  function automatic int unsigned tstate_cost(input grp_e g, input logic hit);
    int unsigned n;
    case (g)
      GRP_JP:   n = TS_JP;
      GRP_CALL: n = hit ? TS_CALL_YES : TS_CALL_NO;
      GRP_RET:  n = hit ? TS_RET_YES : TS_RET_NO;
      default:  n = TS_BAD;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
#(
  parameter int unsigned OP_W = 8,
  localparam int unsigned CC_LSB = 3,
  localparam int unsigned CC_W = 3
) (
  input  logic [OP_W-1:0] opcode_i,
  output grp_e            grp_o,
  output logic [CC_W-1:0] cc_o
);
  assign grp_o = grp_of(opcode_i);
  assign cc_o  = opcode_i[CC_LSB +: CC_W];
endmodule

// File: rtl/brc_cond.sv
module brc_cond
  import brc_pkg::*;
#(
  parameter int unsigned FLAG_W = 8,
  localparam int unsigned CC_W = 3,
  localparam int unsigned N_COND = 1 << CC_W
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic              hit_o
);
  logic [N_COND-1:0] hit_vec;

  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    assign hit_vec[g] = cond_met(CC_W'(g), flags_i[7:0]);
  end

  assign hit_o = hit_vec[cc_i];
endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
#(
  parameter int unsigned PC_W = 16,
  parameter int unsigned TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  grp_e            grp_i,
  input  logic            hit_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] target_i,
  output logic            idle_o,
  output logic            push_req_o,
  output logic [PC_W-1:0] push_data_o,
  output logic            pop_req_o,
  input  logic [PC_W-1:0] pop_data_i,
  input  logic            stack_ack_i,
  output logic            done_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic [TS_W-1:0] tstates_o,
  output logic            taken_o,
  output logic            illegal_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP} st_e;
  st_e st_q;
  logic [PC_W-1:0] tgt_q;

  logic accept_w, need_push_w, need_pop_w, finish_w;
  assign idle_o      = (st_q == ST_IDLE);
  assign accept_w    = start_i && idle_o;
  assign need_push_w = (grp_i == GRP_CALL) && hit_i;
  assign need_pop_w  = (grp_i == GRP_RET) && hit_i;
  assign finish_w    = !idle_o && stack_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      tgt_q       <= '0;
      push_req_o  <= 1'b0;
      push_data_o <= '0;
      pop_req_o   <= 1'b0;
      done_o      <= 1'b0;
      next_pc_o   <= '0;
      tstates_o   <= '0;
      taken_o     <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept_w) begin
            if (need_push_w) begin
              st_q        <= ST_PUSH;
              push_req_o  <= 1'b1;
              push_data_o <= pc_i;
              tgt_q       <= target_i;
            end else if (need_pop_w) begin
              st_q      <= ST_POP;
              pop_req_o <= 1'b1;
            end else begin
              done_o    <= 1'b1;
              next_pc_o <= (grp_i == GRP_JP && hit_i) ? target_i : pc_i;
              tstates_o <= TS_W'(tstate_cost(grp_i, hit_i));
              taken_o   <= hit_i && (grp_i == GRP_JP);
              illegal_o <= (grp_i == GRP_BAD);
            end
          end
        end
        ST_PUSH: begin
          if (stack_ack_i) begin
            st_q       <= ST_IDLE;
            push_req_o <= 1'b0;
            done_o     <= 1'b1;
            next_pc_o  <= tgt_q;
            tstates_o  <= TS_W'(tstate_cost(GRP_CALL, 1'b1));
            taken_o    <= 1'b1;
            illegal_o  <= 1'b0;
          end
        end
        ST_POP: begin
          if (stack_ack_i) begin
            st_q      <= ST_IDLE;
            pop_req_o <= 1'b0;
            done_o    <= 1'b1;
            next_pc_o <= pop_data_i;
            tstates_o <= TS_W'(tstate_cost(GRP_RET, 1'b1));
            taken_o   <= 1'b1;
            illegal_o <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7: the two stack requests are exclusive
  p_one_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_req_o && pop_req_o));

  // R8: an unanswered push holds its request and word
  p_push_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_req_o && !stack_ack_i |=> push_req_o && $stable(push_data_o));

  // R8: an unanswered pop holds its request
  p_pop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req_o && !stack_ack_i |=> pop_req_o && !done_o);

  // R4: an answered push closes a taken call
  p_push_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_req_o && stack_ack_i |=> done_o && taken_o && !push_req_o
      && tstates_o == TS_W'(TS_CALL_YES));

  // R5: an answered pop lands the popped word
  p_pop_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req_o && stack_ack_i |=> done_o && !pop_req_o
      && next_pc_o == $past(pop_data_i));

  // R10: a strobe while busy yields no completion beyond the pending one
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !idle_o && !finish_w |=> !done_o);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brc_pkg::*;
#(
  parameter int unsigned PC_W = 16,
  parameter int unsigned TS_W = 5,
  localparam int unsigned BYTE_W = PC_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        flags_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [BYTE_W-1:0] tgt_lo_i,
  input  logic [BYTE_W-1:0] tgt_hi_i,
  output logic              push_req_o,
  output logic [PC_W-1:0]   push_data_o,
  output logic              pop_req_o,
  input  logic [PC_W-1:0]   pop_data_i,
  input  logic              stack_ack_i,
  output logic              done_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [TS_W-1:0]   tstates_o,
  output logic              taken_o,
  output logic              illegal_o
);
  grp_e            grp_w;
  logic [2:0]      cc_w;
  logic            hit_w;
  logic            idle_w;
  logic [PC_W-1:0] target_w;

  // R6: low byte first
  assign target_w = {tgt_hi_i, tgt_lo_i};

  brc_decode #(.OP_W(8)) i_decode (
    .opcode_i (opcode_i),
    .grp_o    (grp_w),
    .cc_o     (cc_w)
  );

  brc_cond #(.FLAG_W(8)) i_cond (
    .flags_i (flags_i),
    .cc_i    (cc_w),
    .hit_o   (hit_w)
  );

  brc_seq #(.PC_W(PC_W), .TS_W(TS_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .grp_i       (grp_w),
    .hit_i       (hit_w),
    .pc_i        (pc_i),
    .target_i    (target_w),
    .idle_o      (idle_w),
    .push_req_o  (push_req_o),
    .push_data_o (push_data_o),
    .pop_req_o   (pop_req_o),
    .pop_data_i  (pop_data_i),
    .stack_ack_i (stack_ack_i),
    .done_o      (done_o),
    .next_pc_o   (next_pc_o),
    .tstates_o   (tstates_o),
    .taken_o     (taken_o),
    .illegal_o   (illegal_o)
  );

  logic accept_w, stack_w;
  assign accept_w = start_i && idle_w;
  assign stack_w  = hit_w && (grp_w == GRP_CALL || grp_w == GRP_RET);

  // R7: no stack traffic and an immediate done when none is needed
  p_quick_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !stack_w |=> done_o && !push_req_o && !pop_req_o);

  // R9: illegal completions never report a transfer
  p_bad_not_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && illegal_o |-> !taken_o && tstates_o == '0);
endmodule

// File: tb/test_branch_resolve_unit.sv
module test_branch_resolve_unit;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  flags_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  tgt_lo_i = '0;
  logic [7:0]  tgt_hi_i = '0;
  logic        push_req_o;
  logic [15:0] push_data_o;
  logic        pop_req_o;
  logic [15:0] pop_data_i = '0;
  logic        stack_ack_i = 1'b0;
  logic        done_o;
  logic [15:0] next_pc_o;
  logic [4:0]  tstates_o;
  logic        taken_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve_unit i_branch_resolve_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .flags_i(flags_i), .pc_i(pc_i), .tgt_lo_i(tgt_lo_i), .tgt_hi_i(tgt_hi_i),
    .push_req_o(push_req_o), .push_data_o(push_data_o), .pop_req_o(pop_req_o),
    .pop_data_i(pop_data_i), .stack_ack_i(stack_ack_i), .done_o(done_o),
    .next_pc_o(next_pc_o), .tstates_o(tstates_o), .taken_o(taken_o),
    .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // condition outcome restated from R1/R2
  function automatic bit want_hit(input logic [7:0] op, input logic [7:0] fl);
    case (op[5:3])
      3'd0: return !fl[6];
      3'd1: return  fl[6];
      3'd2: return !fl[0];
      3'd3: return  fl[0];
      3'd4: return !fl[2];
      3'd5: return  fl[2];
      3'd6: return !fl[7];
      default: return fl[7];
    endcase
  endfunction

  // 0 jump, 1 call, 2 return, 3 illegal (R3/R4/R5/R9)
  function automatic int kind_of(input logic [7:0] op);
    if (op[7:6] != 2'b11) return 3;
    if (op[2:0] == 3'b010) return 0;
    if (op[2:0] == 3'b100) return 1;
    if (op[2:0] == 3'b000) return 2;
    return 3;
  endfunction

  task automatic run_op(input string req, input logic [7:0] op, input logic [7:0] fl,
                        input logic [15:0] pc, input logic [15:0] tgt,
                        input logic [15:0] popw, input int wait_n, input bit clash);
    int k;
    bit h, stk;
    logic [15:0] e_pc;
    int e_ts;
    k = kind_of(op);
    h = (k != 3) && want_hit(op, fl);
    stk = h && (k == 1 || k == 2);
    case (k)
      0: begin e_ts = 10; e_pc = h ? tgt : pc; end
      1: begin e_ts = h ? 17 : 10; e_pc = h ? tgt : pc; end
      2: begin e_ts = h ? 11 : 5; e_pc = h ? popw : pc; end
      default: begin e_ts = 0; e_pc = pc; end
    endcase
    @(negedge clk);
    opcode_i = op; flags_i = fl; pc_i = pc;
    tgt_lo_i = tgt[7:0]; tgt_hi_i = tgt[15:8];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (stk) begin
      chk(req, "push_req", push_req_o, k == 1);
      chk(req, "pop_req", pop_req_o, k == 2);
      if (k == 1) chk(req, "push_data", push_data_o, pc);
      for (int i = 0; i < wait_n; i++) begin
        @(negedge clk);
        chk("R8", "held req", push_req_o | pop_req_o, 1);
        chk("R8", "early done", done_o, 0);
        if (k == 1) chk("R8", "push word stable", push_data_o, pc);
      end
      stack_ack_i = 1'b1; pop_data_i = popw;
      if (clash) begin
        start_i = 1'b1; opcode_i = 8'h00; pc_i = 16'hdead;
      end
      @(negedge clk);
      stack_ack_i = 1'b0; start_i = 1'b0;
      chk("R8", "req dropped", push_req_o | pop_req_o, 0);
    end else begin
      chk("R7", "no push", push_req_o, 0);
      chk("R7", "no pop", pop_req_o, 0);
    end
    chk(req, "done", done_o, 1);
    chk(req, "next_pc", next_pc_o, e_pc);
    chk(req, "tstates", tstates_o, e_ts);
    chk(req, "taken", taken_o, h);
    chk(req, "illegal", illegal_o, k == 3);
    @(negedge clk);
    chk(clash ? "R10" : "R7", "single done", done_o, 0);
  endtask

  task automatic t_reset;
    chk("R11", "done", done_o, 0);
    chk("R11", "push_req", push_req_o, 0);
    chk("R11", "pop_req", pop_req_o, 0);
    chk("R11", "next_pc", next_pc_o, 0);
    chk("R11", "tstates", tstates_o, 0);
    chk("R11", "taken", taken_o, 0);
    chk("R11", "illegal", illegal_o, 0);
  endtask

  task automatic t_jumps;
    // R1 R2 R3: every condition, flags set and clear
    for (int c = 0; c < 8; c++) begin
      run_op("R3", 8'hC2 | 8'(c << 3), 8'h00, 16'h1003, 16'h4000 + 16'(c), 0, 0, 0);
      run_op("R1", 8'hC2 | 8'(c << 3), 8'hC5, 16'h2003, 16'h5000 + 16'(c), 0, 0, 0);
    end
    // R2: unused flag bits have no effect
    run_op("R2", 8'hCA, 8'h3A, 16'h0100, 16'h0200, 0, 0, 0);
    run_op("R2", 8'hC2, 8'h3A, 16'h0100, 16'h0200, 0, 0, 0);
  endtask

  task automatic t_calls;
    run_op("R4", 8'hDC, 8'h01, 16'h0303, 16'h1234, 0, 0, 0);
    run_op("R4", 8'hD4, 8'h01, 16'h0303, 16'h1234, 0, 0, 0);
    run_op("R4", 8'hFC, 8'h80, 16'hABCD, 16'h8000, 0, 3, 0);
    run_op("R6", 8'hC4, 8'h00, 16'h0010, 16'h1234, 0, 1, 0);
  endtask

  task automatic t_returns;
    run_op("R5", 8'hC8, 8'h40, 16'h0050, 16'h0000, 16'h7777, 0, 0);
    run_op("R5", 8'hC0, 8'h40, 16'h0050, 16'h0000, 16'h7777, 0, 0);
    run_op("R5", 8'hE0, 8'h00, 16'h0060, 16'h0000, 16'hBEEF, 4, 0);
    run_op("R5", 8'hE8, 8'h00, 16'h0060, 16'h0000, 16'hBEEF, 0, 0);
  endtask

  task automatic t_illegal;
    run_op("R9", 8'h00, 8'hFF, 16'h0ABC, 16'h1111, 0, 0, 0);
    run_op("R9", 8'hC3, 8'hFF, 16'h0ABD, 16'h2222, 0, 0, 0);
    run_op("R9", 8'hC9, 8'h00, 16'h0ABE, 16'h3333, 0, 0, 0);
  endtask

  task automatic t_clash;
    // R10: start strobe in the acknowledge cycle
    run_op("R10", 8'hF4, 8'h00, 16'h4444, 16'h9999, 0, 2, 1);
    run_op("R10", 8'hD8, 8'h01, 16'h4445, 16'h0000, 16'h5A5A, 1, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_jumps();
    t_calls();
    t_returns();
    t_illegal();
    t_clash();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule